// File: doc/BRIEF.md
# Column Mix and Round-Key XOR Unit

This block performs one column of the column-mixing step of a 128-bit block-cipher round and folds the round-key addition into the same pass. A processor hands work to it through a shared data memory. The processor places a 32-bit state column at a fixed word and then sets a flag word to 1. The block polls the flag and fetches the column. It also fetches the matching round-key word from an expanded-key memory, using an address that it derives from the column index and the round number. It writes the mixed column XORed with the key back to a result word and then clears the flag, which signals the processor that the result is ready.

The column index and the round number arrive on input ports and stay stable while the flag is set. Both memories are modelled with one cycle of read latency. After each new address, the controller waits one cycle before it uses the returned data. The data memory has one group of four byte enables per column. A write uses only the group of the current column.

Top module: `colmix_keyxor`

## Requirements
- R1: While reset is held and after it is released, no byte enable is raised and the data address rests at the flag word, byte address 0x0.
- R2: Only a flag word exactly equal to 32'h0000_0001 starts an operation. Any other value (0, 2, 32'h8000_0001, all ones) causes no data-memory write.
- R3: Once the flag is seen, the state column is taken from data byte address 0x4.
- R4: The key word is taken from key byte address 0x20 + 4*(col + 4*(round + 1)), for col 0..3 and round 0..8.
- R5: The result is MixColumns(column) XOR key. The column byte in bits [31:24] is row 0 and the byte in bits [7:0] is row 3. The matrix rows are (2,3,1,1), (1,2,3,1), (1,1,2,3), (3,1,1,2), and multiply-by-2 reduces by 0x11B.
- R6: Each operation writes the result exactly once, to data byte address 0x8. The write sets dmem_be[4*col+3 : 4*col] to 4'b1111 and leaves every other enable bit at 0.
- R7: In the cycle after the result write, the block writes 0 to address 0x0 with the same enables. The next cycle has no write, and polling resumes.
- R8: The flag is back at 0 no more than 8 clock cycles after it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_idx | input | 2 | Column index 0..3, stable while the flag is set |
| round_num | input | 4 | Round number 0..8, stable while the flag is set |
| dmem_addr | output | 8 | Data-memory byte address |
| dmem_wdata | output | 32 | Data-memory write word |
| dmem_be | output | 16 | Byte enables, four per column |
| dmem_rdata | input | 32 | Data-memory read word, one cycle after the address |
| kmem_addr | output | 8 | Expanded-key memory byte address |
| kmem_rdata | input | 32 | Key-memory read word, one cycle after the address |

## Verification
The bench sweeps every column at every round 0..8 with several state words. The key memory holds a distinct word at every address, so an error in the address formula gives a wrong result instead of a coincidental match. Known-answer columns and a reference multiply written as a shift-and-add loop catch a wrong matrix row, a swapped byte order or a wrong reduction constant. Near-miss flag values would expose a design that tests only the low bit or any nonzero value. Counts of result writes and clear writes, together with their enables and the measured latency, would expose a design that writes twice, clears too early, uses the enables of another column, or stalls.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W   = 8;
  localparam int WBYTES   = 4;
  localparam int WORD_W   = BYTE_W * WBYTES;
  localparam int NCOL     = 4;

  typedef enum logic [2:0] {
    ST_POLL_ADDR,
    ST_POLL_CHK,
    ST_RD_ADDR,
    ST_RD_CAP,
    ST_WRITE,
    ST_CLEAR
  } cm_state_e;

  // multiply by 2 in GF(2^8), reduction by x^8+x^4+x^3+x+1
  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    gf_dbl = {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? 8'h1B : 8'h00);
  endfunction
endpackage

// File: rtl/cm_gf_mixer.sv
module cm_gf_mixer
  import colmix_pkg::*;
(
  input  logic [WORD_W-1:0] col_in,
  output logic [WORD_W-1:0] col_out
);
  localparam int NROW = WBYTES;

  logic [BYTE_W-1:0] a [NROW];
  logic [BYTE_W-1:0] m [NROW];

  for (genvar r = 0; r < NROW; r++) begin : g_row
    localparam int IDX1 = (r + 1) % NROW;
    localparam int IDX2 = (r + 2) % NROW;
    localparam int IDX3 = (r + 3) % NROW;
    assign a[r] = col_in[WORD_W-1-BYTE_W*r -: BYTE_W];
    // coefficient 2 on own row, 3 on next, 1 on the other two
    assign m[r] = gf_dbl(a[r]) ^ gf_dbl(a[IDX1]) ^ a[IDX1] ^ a[IDX2] ^ a[IDX3];
    assign col_out[WORD_W-1-BYTE_W*r -: BYTE_W] = m[r];
  end

  // each matrix column sums to 1, so the byte-XOR of the column is preserved
  always_comb begin
    if (!$isunknown(col_in)) begin
      // R5
      mix_parity_chk: assert ((m[0] ^ m[1] ^ m[2] ^ m[3]) == (a[0] ^ a[1] ^ a[2] ^ a[3]));
    end
  end
endmodule

// File: rtl/cm_key_addr.sv
module cm_key_addr
  import colmix_pkg::*;
#(
  parameter int KADDR_W  = 8,
  parameter int COL_W    = 2,
  parameter int RND_W    = 4,
  parameter int KEY_BASE = 32'h20
) (
  input  logic [COL_W-1:0]   col,
  input  logic [RND_W-1:0]   rnd,
  output logic [KADDR_W-1:0] key_addr
);
  localparam int WORD_IDX_W = COL_W + RND_W + 2;

  logic [WORD_IDX_W-1:0] word_idx;

  // word index inside the expanded key: the first round key is skipped
  always_comb begin
    word_idx = WORD_IDX_W'(col) + WORD_IDX_W'(NCOL) * (WORD_IDX_W'(rnd) + WORD_IDX_W'(1));
    key_addr = KADDR_W'(KEY_BASE) + KADDR_W'(word_idx) * KADDR_W'(WBYTES);
  end
endmodule

// File: rtl/cm_ctrl.sv
module cm_ctrl
  import colmix_pkg::*;
#(
  parameter logic [31:0] FLAG_SET = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] flag_word,
  output logic              rd_phase,
  output logic              cap_en,
  output logic              wr_result,
  output logic              wr_clear
);
  cm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POLL_ADDR: st_d = ST_POLL_CHK;
      ST_POLL_CHK:  if (flag_word == FLAG_SET) st_d = ST_RD_ADDR;
      ST_RD_ADDR:   st_d = ST_RD_CAP;
      ST_RD_CAP:    st_d = ST_WRITE;
      ST_WRITE:     st_d = ST_CLEAR;
      ST_CLEAR:     st_d = ST_POLL_ADDR;
      default:      st_d = ST_POLL_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_POLL_ADDR;
    else        st_q <= st_d;
  end

  assign rd_phase  = (st_q == ST_RD_ADDR) || (st_q == ST_RD_CAP);
  assign cap_en    = (st_q == ST_RD_CAP);
  assign wr_result = (st_q == ST_WRITE);
  assign wr_clear  = (st_q == ST_CLEAR);

  // R2
  start_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POLL_CHK && flag_word != FLAG_SET) |=> (st_q == ST_POLL_CHK));
endmodule

// File: rtl/colmix_keyxor.sv
module colmix_keyxor
  import colmix_pkg::*;
#(
  parameter int          DADDR_W     = 8,
  parameter int          KADDR_W     = 8,
  parameter int          COL_W       = 2,
  parameter int          RND_W       = 4,
  parameter int          FLAG_ADDR   = 32'h0,
  parameter int          STATE_ADDR  = 32'h4,
  parameter int          RESULT_ADDR = 32'h8,
  parameter int          KEY_BASE    = 32'h20,
  parameter logic [31:0] FLAG_SET    = 32'h1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [COL_W-1:0]        col_idx,
  input  logic [RND_W-1:0]        round_num,
  output logic [DADDR_W-1:0]      dmem_addr,
  output logic [WORD_W-1:0]       dmem_wdata,
  output logic [NCOL*WBYTES-1:0]  dmem_be,
  input  logic [WORD_W-1:0]       dmem_rdata,
  output logic [KADDR_W-1:0]      kmem_addr,
  input  logic [WORD_W-1:0]       kmem_rdata
);
  localparam int BE_W = NCOL * WBYTES;
  localparam logic [BE_W-1:0] LANE_ONES = BE_W'({WBYTES{1'b1}});

  logic              rd_phase, cap_en, wr_result, wr_clear;
  logic [WORD_W-1:0] col_q, key_q, mixed;
  logic [BE_W-1:0]   lane_mask;

  cm_ctrl #(.FLAG_SET(FLAG_SET)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_word (dmem_rdata),
    .rd_phase  (rd_phase),
    .cap_en    (cap_en),
    .wr_result (wr_result),
    .wr_clear  (wr_clear)
  );

  cm_key_addr #(
    .KADDR_W (KADDR_W),
    .COL_W   (COL_W),
    .RND_W   (RND_W),
    .KEY_BASE(KEY_BASE)
  ) u_kaddr (
    .col     (col_idx),
    .rnd     (round_num),
    .key_addr(kmem_addr)
  );

  cm_gf_mixer u_mix (
    .col_in (col_q),
    .col_out(mixed)
  );

  // capture column and key with an explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      key_q <= '0;
    end else if (cap_en) begin
      col_q <= dmem_rdata;
      key_q <= kmem_rdata;
    end
  end

  always_comb begin
    lane_mask = LANE_ONES << (WBYTES * int'(col_idx));
    if (wr_result)     dmem_addr = DADDR_W'(RESULT_ADDR);
    else if (rd_phase) dmem_addr = DADDR_W'(STATE_ADDR);
    else               dmem_addr = DADDR_W'(FLAG_ADDR);
    dmem_wdata = wr_result ? (mixed ^ key_q) : '0;
    dmem_be    = (wr_result || wr_clear) ? lane_mask : '0;
  end

  // R1
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_be == '0 && !rd_phase) |-> (dmem_addr == DADDR_W'(FLAG_ADDR)));

  // R2
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_be != '0) |-> (dmem_addr == DADDR_W'(RESULT_ADDR) || dmem_addr == DADDR_W'(FLAG_ADDR)));

  // R3
  state_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (dmem_addr == DADDR_W'(STATE_ADDR) && $past(dmem_addr) == DADDR_W'(STATE_ADDR)));

  // R4
  key_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (kmem_addr[1:0] == 2'b00 && kmem_addr >= KADDR_W'(KEY_BASE + NCOL * WBYTES)));

  // R6
  result_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_be != '0 && dmem_addr == DADDR_W'(RESULT_ADDR)) |->
      ($countones(dmem_be) == WBYTES && dmem_be[WBYTES*int'(col_idx) +: WBYTES] == '1));

  // R7
  clear_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_be != '0 && dmem_addr == DADDR_W'(RESULT_ADDR)) |=>
      (dmem_addr == DADDR_W'(FLAG_ADDR) && dmem_wdata == '0 && $stable(dmem_be)));

  // R7
  quiet_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_be != '0 && dmem_addr == DADDR_W'(FLAG_ADDR)) |=> (dmem_be == '0));
endmodule

// File: tb/colmix_keyxor_tb.sv
module colmix_keyxor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  col_idx;
  logic [3:0]  round_num;
  logic [7:0]  dmem_addr;
  logic [31:0] dmem_wdata;
  logic [15:0] dmem_be;
  logic [31:0] dmem_rdata;
  logic [7:0]  kmem_addr;
  logic [31:0] kmem_rdata;

  logic [31:0] dmem [64];
  logic [31:0] kmem [64];
  logic        tb_we;
  logic [5:0]  tb_widx;
  logic [31:0] tb_wdata;

  int n_chk = 0, n_err = 0, cyc = 0;
  int res_cnt = 0, clr_cnt = 0, bad_cnt = 0;
  logic [15:0] last_res_be, last_clr_be;
  logic [31:0] last_clr_data;

  always #5 clk = ~clk;

  colmix_keyxor u_dut (
    .clk(clk), .rst_n(rst_n), .col_idx(col_idx), .round_num(round_num),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_be(dmem_be),
    .dmem_rdata(dmem_rdata), .kmem_addr(kmem_addr), .kmem_rdata(kmem_rdata)
  );

  function automatic logic [31:0] kpat(input int i);
    kpat = (32'h9E3779B9 * (i + 1)) ^ (i << 16);
  endfunction

  initial for (int i = 0; i < 64; i++) kmem[i] = kpat(i);

  // memory model: one cycle read latency, read-before-write
  always @(posedge clk) begin
    dmem_rdata <= dmem[dmem_addr[7:2]];
    kmem_rdata <= kmem[kmem_addr[7:2]];
    if (tb_we) dmem[tb_widx] <= tb_wdata;
    if (rst_n && dmem_be != 16'h0) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      if (dmem_addr == 8'h08) begin res_cnt <= res_cnt + 1; last_res_be <= dmem_be; end
      else if (dmem_addr == 8'h00) begin
        clr_cnt <= clr_cnt + 1; last_clr_be <= dmem_be; last_clr_data <= dmem_wdata;
      end else bad_cnt <= bad_cnt + 1;
    end
  end

  function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] p, aa, bb;
    p = 0; aa = x; bb = y;
    for (int k = 0; k < 8; k++) begin
      if (bb[0]) p = p ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
      bb = bb >> 1;
    end
    gmul = p;
  endfunction

  function automatic logic [31:0] ref_mix(input logic [31:0] s);
    logic [7:0] b0, b1, b2, b3;
    {b0, b1, b2, b3} = s;
    ref_mix = {gmul(b0,2) ^ gmul(b1,3) ^ b2 ^ b3,
               b0 ^ gmul(b1,2) ^ gmul(b2,3) ^ b3,
               b0 ^ b1 ^ gmul(b2,2) ^ gmul(b3,3),
               gmul(b0,3) ^ b1 ^ b2 ^ gmul(b3,2)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bench_write(input int idx, input logic [31:0] val);
    @(negedge clk); tb_we = 1'b1; tb_widx = 6'(idx); tb_wdata = val;
    @(negedge clk); tb_we = 1'b0;
  endtask

  // one column operation; fixed_exp used when use_fixed is set
  task automatic run_op(input int c, input int r, input logic [31:0] st,
                        input logic use_fixed, input logic [31:0] fixed_mix);
    int r0, c0, lat;
    int kidx;
    logic [31:0] exp;
    @(negedge clk); col_idx = 2'(c); round_num = 4'(r);
    bench_write(1, st);
    r0 = res_cnt; c0 = clr_cnt;
    bench_write(0, 32'h1);
    lat = 1;
    while (dmem[0] != 32'h0 && lat < 20) begin @(negedge clk); lat++; end
    repeat (2) @(negedge clk);
    kidx = 8 + c + 4 * (r + 1);
    exp  = (use_fixed ? fixed_mix : ref_mix(st)) ^ kpat(kidx);
    // R3 R4 R5: state from 0x4, key from computed address, mixed
    chk(dmem[2] == exp, "R5 result (R3 state, R4 key)", dmem[2], exp);
    chk(res_cnt - r0 == 1, "R6 one result write", 32'(res_cnt - r0), 32'd1);
    chk(last_res_be == (16'hF << (4 * c)), "R6 result enables", 32'(last_res_be), 32'(16'hF << (4*c)));
    chk(clr_cnt - c0 == 1 && last_clr_data == 0, "R7 flag clear", last_clr_data, 32'd0);
    chk(last_clr_be == (16'hF << (4 * c)), "R7 clear enables", 32'(last_clr_be), 32'(16'hF << (4*c)));
    chk(lat <= 8, "R8 latency", 32'(lat), 32'd8);
  endtask

  task automatic no_start(input logic [31:0] fv);
    int w0;
    logic [31:0] keep;
    keep = dmem[2];
    w0 = res_cnt + clr_cnt + bad_cnt;
    bench_write(0, fv);
    repeat (12) @(negedge clk);
    chk(res_cnt + clr_cnt + bad_cnt == w0, "R2 no write on flag value", fv, 32'h1);
    chk(dmem[2] == keep && dmem[0] == fv, "R2 memory untouched", dmem[2], keep);
    bench_write(0, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    tb_we = 0; tb_widx = 0; tb_wdata = 0; col_idx = 0; round_num = 0;
    last_res_be = 0; last_clr_be = 0; last_clr_data = 32'hFFFF_FFFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(dmem_be == 0 && dmem_addr == 8'h00, "R1 reset outputs", {dmem_be, 8'h0, dmem_addr}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(dmem_be == 0 && dmem_addr == 8'h00, "R1 after reset", {dmem_be, 8'h0, dmem_addr}, 32'h0);
    end
    // R2 near-miss flag values
    no_start(32'h0000_0002);
    no_start(32'h8000_0001);
    no_start(32'hFFFF_FFFF);
    no_start(32'h0000_0101);
    // R5 known-answer columns
    run_op(0, 0, 32'hDB135345, 1'b1, 32'h8E4DA1BC);
    run_op(1, 3, 32'hD4D4D4D5, 1'b1, 32'hD5D5D7D6);
    run_op(2, 5, 32'hF2F2F2F2, 1'b1, 32'hF2F2F2F2);
    run_op(3, 8, 32'h2D26314C, 1'b1, 32'h4D7EBDF8);
    // full sweep of column and round, several states each
    for (int r = 0; r <= 8; r++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 3; p++)
          run_op(c, r, (32'h01234567 * (r * 12 + c * 3 + p + 1)) ^ 32'hA5C3_0F81, 1'b0, 32'h0);
    // R6 no stray write anywhere else
    chk(bad_cnt == 0, "R6 no write to other address", 32'(bad_cnt), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule